// File: doc/BRIEF.md
# Windowed Register Stack Frame Mapper

This block converts a logical general-register number into an index in the physical register file of a windowed register stack. The low 32 logical registers are global and keep their own index. Each register from 32 upward is relative to the current procedure's frame, so logical 32 is always the first physical register of that frame. The stacked pool is circular, and indices wrap around its end.

Three operations change the frame. An allocate sets the frame size and the number of output registers. A call moves the frame base past the caller's inputs and locals. The caller's output registers then become the callee's first registers, with no data copied. A call also saves the caller's frame marker (base, size and output count) on a small LIFO. A return pops that marker and restores it. The block does not spill registers to memory or fill them back. When an operation would exceed the pool or the marker stack, the block raises a flag and leaves the frame as it was.

The translation port is combinational and follows the current frame. The flags and the frame registers update on the clock edge after an operation.

Top module: `stack_frame_mapper`

## Requirements
- R1: After reset, the frame base, frame size and output count are all 0, and neither the overflow flag nor the underflow flag is set.
- R2: A logical register below 32 gives `phys_stacked`=0 and `phys_idx` equal to the logical number, whatever the frame state.
- R3: A logical register n of 32 or more gives `phys_stacked`=1 and `phys_idx`=(base + n − 32) mod 128. `reg_illegal` is 1 exactly when n − 32 ≥ frame size.
- R4: `op_kind`=1 (allocate) sets the frame size to `alloc_size` and the output count to `alloc_outs` on the next edge. The request is ignored with no flag when `alloc_size` > 96 or `alloc_outs` > `alloc_size`.
- R5: `op_kind`=2 (call) adds (size − outputs) to the base modulo 128, sets the size to the old output count and clears the output count. The caller's logical register 32+size−outputs+k then maps to the same physical register as the callee's logical 32+k.
- R6: `op_kind`=3 (return) restores the base, size and output count saved by the matching call, all in one cycle.
- R7: `overflow` pulses for one cycle and the frame is unchanged in either of two cases. One is an accepted allocate after which the registers held by callers plus the new size would exceed 128. The other is a call when all 8 marker entries are in use.
- R8: `underflow` pulses for one cycle and the frame is unchanged when a return finds the marker stack empty.
- R9: `op_kind`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 2 | 0 none, 1 allocate, 2 call, 3 return |
| alloc_size | input | 7 | Frame size for allocate |
| alloc_outs | input | 7 | Output count for allocate |
| lreg | input | 7 | Logical register to translate |
| phys_stacked | output | 1 | 1 when the index refers to the stacked pool |
| phys_idx | output | 7 | Physical index (global or pool) |
| reg_illegal | output | 1 | Logical register lies beyond the current frame |
| frame_base | output | 7 | Pool index of the current frame's first register |
| frame_size | output | 7 | Current frame size |
| frame_outs | output | 7 | Current output count |
| overflow | output | 1 | Pool or marker stack would be exceeded |
| underflow | output | 1 | Return with no saved marker |

## Verification
An operation presented before a rising edge shows up in the frame registers and flags right after that edge. Translation is combinational, so it reflects the updated frame in the same cycle. The bench drives each operation, together with a new logical register, on a falling edge. It samples everything on the next falling edge, half a period after the one edge that applies the operation, and clears the operation there. The flag pulses are also checked to be low again once an idle cycle has passed.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ALLOC = 2'd1,
        OP_CALL  = 2'd2,
        OP_RET   = 2'd3
    } sfm_op_e;
endpackage

// File: rtl/sfm_marker_lifo.sv
module sfm_marker_lifo #(
    parameter int ENTRY_W = 21,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic [ENTRY_W-1:0] push_data,
    output logic [ENTRY_W-1:0] top_data,
    output logic               empty,
    output logic               full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ENTRY_W-1:0] mem_q [DEPTH];
    logic [ENTRY_W-1:0] mem_d [DEPTH];
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [PTR_W-1:0]   top_ptr;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign top_ptr = empty ? '0 : PTR_W'(cnt_q - 1'b1);
    assign top_data = mem_q[top_ptr];

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        if (push && !full) begin
            mem_d[PTR_W'(cnt_q)] = push_data;
            cnt_d = cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end

    assert_lifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    assert_lifo_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sfm_translate.sv
module sfm_translate #(
    parameter int LREG_W      = 7,
    parameter int PIDX_W      = 7,
    parameter int SIZE_W      = 7,
    parameter int NUM_GLOBALS = 32
) (
    input  logic [LREG_W-1:0] lreg,
    input  logic [PIDX_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    output logic              stacked,
    output logic [PIDX_W-1:0] idx,
    output logic              illegal
);
    localparam int OFF_W = (LREG_W > SIZE_W) ? LREG_W : SIZE_W;

    logic [OFF_W-1:0] off;

    always_comb begin
        off = OFF_W'(lreg) - OFF_W'(NUM_GLOBALS);
        if (lreg < LREG_W'(NUM_GLOBALS)) begin
            stacked = 1'b0;
            idx     = PIDX_W'(lreg);
            illegal = 1'b0;
        end else begin
            stacked = 1'b1;
            idx     = base + PIDX_W'(off);
            illegal = (off >= OFF_W'(size));
        end
    end
endmodule

// File: rtl/stack_frame_mapper.sv
module stack_frame_mapper #(
    parameter int POOL        = 128,
    parameter int MAX_FRAME   = 96,
    parameter int MARKERS     = 8,
    parameter int NUM_GLOBALS = 32,
    parameter int LREG_W      = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   op_kind,
    input  logic [$clog2(MAX_FRAME+1)-1:0] alloc_size,
    input  logic [$clog2(MAX_FRAME+1)-1:0] alloc_outs,
    input  logic [LREG_W-1:0]            lreg,
    output logic                         phys_stacked,
    output logic [$clog2(POOL)-1:0]      phys_idx,
    output logic                         reg_illegal,
    output logic [$clog2(POOL)-1:0]      frame_base,
    output logic [$clog2(MAX_FRAME+1)-1:0] frame_size,
    output logic [$clog2(MAX_FRAME+1)-1:0] frame_outs,
    output logic                         overflow,
    output logic                         underflow
);
    import sfm_pkg::*;

    localparam int PIDX_W  = $clog2(POOL);
    localparam int SIZE_W  = $clog2(MAX_FRAME + 1);
    localparam int USED_W  = $clog2(POOL + 1);
    localparam int ENTRY_W = PIDX_W + 2 * SIZE_W;

    typedef struct packed {
        logic [PIDX_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic [SIZE_W-1:0] outs;
    } marker_t;

    typedef struct packed {
        marker_t           frm;
        logic [USED_W-1:0] used;
        logic              ovf;
        logic              unf;
    } state_t;

    state_t  st_d, st_q;
    sfm_op_e op;
    logic    push, pop, lifo_empty, lifo_full;
    marker_t top_m;
    logic [ENTRY_W-1:0] top_raw;
    logic [SIZE_W-1:0]  keep;

    assign op    = sfm_op_e'(op_kind);
    assign top_m = marker_t'(top_raw);
    assign keep  = st_q.frm.size - st_q.frm.outs;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        case (op)
            OP_ALLOC: begin
                if (alloc_size <= SIZE_W'(MAX_FRAME) && alloc_outs <= alloc_size) begin
                    if ((USED_W+1)'(st_q.used) + (USED_W+1)'(alloc_size) > (USED_W+1)'(POOL)) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        st_d.frm.size = alloc_size;
                        st_d.frm.outs = alloc_outs;
                    end
                end
            end
            OP_CALL: begin
                if (lifo_full) begin
                    st_d.ovf = 1'b1;
                end else begin
                    push          = 1'b1;
                    st_d.frm.base = st_q.frm.base + PIDX_W'(keep);
                    st_d.used     = st_q.used + USED_W'(keep);
                    st_d.frm.size = st_q.frm.outs;
                    st_d.frm.outs = '0;
                end
            end
            OP_RET: begin
                if (lifo_empty) begin
                    st_d.unf = 1'b1;
                end else begin
                    pop       = 1'b1;
                    st_d.frm  = top_m;
                    st_d.used = st_q.used - USED_W'(top_m.size - top_m.outs);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sfm_marker_lifo #(.ENTRY_W(ENTRY_W), .DEPTH(MARKERS)) i_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (st_q.frm),
        .top_data  (top_raw),
        .empty     (lifo_empty),
        .full      (lifo_full)
    );

    sfm_translate #(
        .LREG_W(LREG_W), .PIDX_W(PIDX_W), .SIZE_W(SIZE_W), .NUM_GLOBALS(NUM_GLOBALS)
    ) i_xlate (
        .lreg    (lreg),
        .base    (st_q.frm.base),
        .size    (st_q.frm.size),
        .stacked (phys_stacked),
        .idx     (phys_idx),
        .illegal (reg_illegal)
    );

    assign frame_base = st_q.frm.base;
    assign frame_size = st_q.frm.size;
    assign frame_outs = st_q.frm.outs;
    assign overflow   = st_q.ovf;
    assign underflow  = st_q.unf;

    assert_globals_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lreg < LREG_W'(NUM_GLOBALS)) |-> (!phys_stacked && phys_idx == PIDX_W'(lreg)));
    assert_frame_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_size <= SIZE_W'(MAX_FRAME) && frame_outs <= frame_size);
    assert_call_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL && !lifo_full) |=>
        (frame_base == $past(frame_base + PIDX_W'(frame_size - frame_outs))
         && frame_size == $past(frame_outs)));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.used <= USED_W'(POOL));
    assert_underflow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> ($stable(frame_base) && $stable(frame_size) && $stable(frame_outs)));
    assert_flags_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));
endmodule

// File: tb/test_stack_frame_mapper.sv
module test_stack_frame_mapper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [6:0] alloc_size = '0, alloc_outs = '0, lreg = '0;
    logic       phys_stacked, reg_illegal, overflow, underflow;
    logic [6:0] phys_idx, frame_base, frame_size, frame_outs;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    int m_base = 0, m_size = 0, m_outs = 0, m_used = 0, m_sp = 0;
    int m_ovf = 0, m_unf = 0;
    int sb [8], ss [8], so [8];

    always #10 clk = ~clk;

    stack_frame_mapper i_stack_frame_mapper (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind),
        .alloc_size(alloc_size), .alloc_outs(alloc_outs), .lreg(lreg),
        .phys_stacked(phys_stacked), .phys_idx(phys_idx), .reg_illegal(reg_illegal),
        .frame_base(frame_base), .frame_size(frame_size), .frame_outs(frame_outs),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_idx(int r);
        if (r < 32) return r;
        return (m_base + r - 32) % 128;
    endfunction

    task automatic model_op(int k, int sz, int ou);
        m_ovf = 0; m_unf = 0;
        if (k == 1) begin
            if (sz <= 96 && ou <= sz) begin
                if (m_used + sz > 128) m_ovf = 1;
                else begin m_size = sz; m_outs = ou; end
            end
        end else if (k == 2) begin
            if (m_sp == 8) m_ovf = 1;
            else begin
                sb[m_sp] = m_base; ss[m_sp] = m_size; so[m_sp] = m_outs; m_sp++;
                m_base = (m_base + m_size - m_outs) % 128;
                m_used = m_used + m_size - m_outs;
                m_size = m_outs; m_outs = 0;
            end
        end else if (k == 3) begin
            if (m_sp == 0) m_unf = 1;
            else begin
                m_sp--;
                m_base = sb[m_sp]; m_size = ss[m_sp]; m_outs = so[m_sp];
                m_used = m_used - (ss[m_sp] - so[m_sp]);
            end
        end
    endtask

    task automatic check_all(string req);
        chk(req, "frame_base", frame_base, m_base);
        chk(req, "frame_size", frame_size, m_size);
        chk(req, "frame_outs", frame_outs, m_outs);
        chk("R7", "overflow", overflow, m_ovf);
        chk("R8", "underflow", underflow, m_unf);
        if (lreg < 32) begin
            chk("R2", "phys_stacked", phys_stacked, 0);
            chk("R2", "phys_idx", phys_idx, lreg);
        end else begin
            chk("R3", "phys_stacked", phys_stacked, 1);
            chk("R3", "phys_idx", phys_idx, exp_idx(lreg));
            chk("R3", "reg_illegal", reg_illegal, (lreg - 32 >= m_size) ? 1 : 0);
        end
    endtask

    task automatic do_op(string req, int k, int sz, int ou, int r);
        @(negedge clk);
        op_kind = 2'(k); alloc_size = 7'(sz); alloc_outs = 7'(ou); lreg = 7'(r);
        model_op(k, sz, ou);
        @(negedge clk);
        op_kind = 2'd0;
        check_all(req);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        lreg = 7'd40;
        @(negedge clk);
        // R1 reset state
        chk("R1", "frame_base", frame_base, 0);
        chk("R1", "frame_size", frame_size, 0);
        chk("R1", "frame_outs", frame_outs, 0);
        chk("R1", "overflow", overflow, 0);
        chk("R1", "underflow", underflow, 0);
        rst_n = 1'b1;

        do_op("R2", 0, 0, 0, 5);
        do_op("R4", 1, 10, 4, 33);
        chk("R3", "r33 idx", phys_idx, 1);
        do_op("R3", 0, 0, 0, 42);
        chk("R3", "r42 illegal", reg_illegal, 1);
        do_op("R5", 0, 0, 0, 38);
        chk("R5", "caller out idx", phys_idx, 6);
        do_op("R5", 2, 0, 0, 32);
        chk("R5", "callee r32 idx", phys_idx, 6);
        do_op("R6", 3, 0, 0, 41);
        chk("R6", "restored size", frame_size, 10);
        do_op("R8", 3, 0, 0, 0);
        chk("R8", "underflow pulse", underflow, 1);
        do_op("R9", 0, 0, 0, 0);
        chk("R8", "underflow cleared", underflow, 0);
        do_op("R4", 1, 97, 0, 100);
        chk("R4", "oversize ignored", frame_size, 10);
        do_op("R4", 1, 5, 6, 34);
        chk("R4", "outs>size ignored", frame_outs, 4);
        do_op("R4", 1, 96, 0, 127);
        do_op("R5", 2, 0, 0, 32);
        do_op("R7", 1, 40, 2, 50);
        chk("R7", "pool overflow", overflow, 1);
        do_op("R9", 0, 0, 0, 60);
        chk("R7", "overflow cleared", overflow, 0);
        do_op("R6", 3, 0, 0, 32);
        do_op("R4", 1, 0, 0, 32);
        for (int i = 0; i < 9; i++) do_op("R7", 2, 0, 0, 32 + i);
        chk("R7", "marker full overflow", overflow, 1);
        for (int i = 0; i < 8; i++) do_op("R6", 3, 0, 0, 90);
        do_op("R8", 3, 0, 0, 3);

        for (int i = 0; i < 1500; i++) begin
            int k, sz, ou;
            k  = $urandom % 4;
            sz = $urandom % 104;
            ou = $urandom % (sz + 3);
            if ((i % 7) == 0) ou = $urandom % (sz / 2 + 1);
            do_op((k == 1) ? "R4" : (k == 2) ? "R5" : (k == 3) ? "R6" : "R9",
                  k, sz, ou, $urandom % 128);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule